// File: doc/BRIEF.md
# Transport Stream Output Port

This block sits at the end of a receive chain and hands byte-aligned transport packets to an external device over a five-signal stream port: a data clock, a data bus, a packet-start strobe, a data-valid strobe and an error strobe. Bytes arrive from the upstream logic, one per cycle when `in_valid` is high, together with a packet-start flag and a packet-error flag. A small FIFO decouples that arrival rate from the slower output rate. The output clock is produced by dividing the system clock, and a 3-bit rate code selects the spacing.

At run time the port can send each byte as a parallel word in one output clock period, or as a serial bit stream, most significant bit first, over eight periods on data bit 0. The output clock can run continuously, or run only while a byte is being sent and rest at its idle level otherwise. The capture edge of the clock and the active level of each of the three strobes are chosen independently. A single enable stops the port and holds every output pin low.

Top module: `mso_stream_out`

## Requirements
- R1: While reset is asserted, the FIFO is empty, the output clock phase is low, no byte is active, and `ovf` is 0. With `cfg_oe`=1 and all polarity bits 0, every output pin reads 0.
- R2: In parallel mode (`cfg_serial`=0), each byte is driven on `ts_data` for exactly one output clock period, with `ts_valid` active for that period.
- R3: In serial mode (`cfg_serial`=1), each byte is sent on `ts_data[0]` over eight consecutive output clock periods, bit 7 first. The other data bits are 0.
- R4: The sync strobe is active only for the first output period of a packet. In parallel mode that is the byte that carried `in_sop`=1. In serial mode it is only the first bit of that byte.
- R5: `in_err` is sampled with the packet-start byte. The error strobe is then active during every output period of that packet's bytes, and `in_err` on the other bytes is ignored.
- R6: Each strobe pin equals its active state XOR its polarity bit: `cfg_sync_low`, `cfg_valid_low` and `cfg_err_low`, where 1 means active low. While no byte is active, data pins are 0.
- R7: With `cfg_clk_fall`=0, data changes on the falling edge of `ts_clk` and is captured on the rising edge. With `cfg_clk_fall`=1, the clock is inverted, so capture is on the falling edge.
- R8: With `cfg_clk_cont`=1, `ts_clk` toggles all the time. With `cfg_clk_cont`=0, it toggles only during periods that carry a byte, and otherwise rests at its idle level, which is `cfg_clk_fall`.
- R9: The output clock period is twice a half-period chosen by `cfg_rate`. The half-periods for codes 0 to 7 are 1, 3, 5, 7, 9, 13, 17 and 20 system cycles. A new output period begins when the clock phase falls.
- R10: With `cfg_oe`=0, every output pin is held at 0 and no byte is taken from the FIFO.
- R11: A byte written while the FIFO holds DEPTH entries is dropped. `ovf` pulses high for one cycle, in the cycle after that write.
- R12: Bytes leave the port in the order they were accepted. Each new byte is fetched at the start of a period in which no serial byte is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | DATA_W | Input byte |
| in_sop | input | 1 | Input byte starts a packet |
| in_err | input | 1 | Packet is uncorrectable (sampled with the start byte) |
| cfg_oe | input | 1 | Port enable |
| cfg_serial | input | 1 | 1 selects serial output, 0 selects parallel output |
| cfg_clk_cont | input | 1 | 1 selects a continuous clock, 0 a gated clock |
| cfg_clk_fall | input | 1 | 1 selects falling-edge capture, 0 rising-edge capture |
| cfg_sync_low | input | 1 | Sync strobe is active low |
| cfg_valid_low | input | 1 | Valid strobe is active low |
| cfg_err_low | input | 1 | Error strobe is active low |
| cfg_rate | input | 3 | Output clock rate code |
| ts_clk | output | 1 | Output data clock |
| ts_data | output | DATA_W | Output data (serial mode uses bit 0) |
| ts_sync | output | 1 | Packet start strobe |
| ts_valid | output | 1 | Data valid strobe |
| ts_err | output | 1 | Packet error strobe |
| ovf | output | 1 | FIFO overflow pulse |

## Verification
The bench builds the port with DATA_W=8, DEPTH=4 and CNT_W=5. The four-entry FIFO lets a burst of six back-to-back writes, sent while the port is disabled, reach the overflow case: the first four bytes are kept and the last two are dropped. Those stored bytes are then drained in order. Rate codes 0 to 3 keep serial bytes short enough that both output modes, both clock modes, every polarity bit and mid-run changes of the rate code are all reached within a short run.

// File: rtl/mso_pkg.sv
package mso_pkg;
   localparam int MSO_MAX_HALF = 20;

   typedef logic [2:0] mso_rate_t;

   // half-period of the output clock in system cycles, one point inside each band
   function automatic int half_len(input mso_rate_t code);
      case (code)
         3'd0:    half_len = 1;
         3'd1:    half_len = 3;
         3'd2:    half_len = 5;
         3'd3:    half_len = 7;
         3'd4:    half_len = 9;
         3'd5:    half_len = 13;
         3'd6:    half_len = 17;
         default: half_len = MSO_MAX_HALF;
      endcase
   endfunction
endpackage

// File: rtl/mso_fifo.sv
module mso_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if ((1 << AW) != DEPTH) begin : g_depth_chk
      $error("mso_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          wr_ok, rd_ok;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign wr_ok   = wr_en && !full;
   assign rd_ok   = rd_en && !empty;
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_ok) wp <= wp + 1'b1;
         if (rd_ok) rp <= rp + 1'b1;
         cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
      end
   end
endmodule

// File: rtl/mso_clkdiv.sv
module mso_clkdiv #(
   parameter int CNT_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  mso_pkg::mso_rate_t rate,
   output logic            ph,
   output logic            boundary
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;
   logic             wrap;

   assign half_m1  = CNT_W'(mso_pkg::half_len(rate) - 1);
   assign wrap     = (cnt >= half_m1);
   assign boundary = wrap && ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ph  <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         ph  <= ~ph;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mso_stream_out.sv
module mso_stream_out #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_err,
   input  logic              cfg_oe,
   input  logic              cfg_serial,
   input  logic              cfg_clk_cont,
   input  logic              cfg_clk_fall,
   input  logic              cfg_sync_low,
   input  logic              cfg_valid_low,
   input  logic              cfg_err_low,
   input  logic [2:0]        cfg_rate,
   output logic              ts_clk,
   output logic [DATA_W-1:0] ts_data,
   output logic              ts_sync,
   output logic              ts_valid,
   output logic              ts_err,
   output logic              ovf
);
   localparam int ENT_W = DATA_W + 2;
   localparam int BIT_W = $clog2(DATA_W);

   if (DATA_W < 2) begin : g_dw_chk
      $error("mso_stream_out: DATA_W must be at least 2");
   end
   if (DEPTH < 2) begin : g_depth_chk
      $error("mso_stream_out: DEPTH must be at least 2");
   end
   if ((1 << CNT_W) <= mso_pkg::MSO_MAX_HALF) begin : g_cnt_chk
      $error("mso_stream_out: CNT_W too narrow for the slowest rate");
   end

   // FIFO entry: {sop, err, data}
   logic [ENT_W-1:0]  wr_ent, rd_ent;
   logic              empty, full, rd_en;
   logic              cur_err;
   logic              ph, boundary;
   logic              act, sop_q, err_q;
   logic [DATA_W-1:0] sh;
   logic [BIT_W-1:0]  bits_left;
   logic              mid_byte;

   assign wr_ent = {in_sop, (in_sop ? in_err : cur_err), in_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cur_err <= 1'b0;
      else if (in_valid && in_sop) cur_err <= in_err;
   end

   mso_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid),
      .wr_data (wr_ent),
      .rd_en   (rd_en),
      .rd_data (rd_ent),
      .empty   (empty),
      .full    (full)
   );

   mso_clkdiv #(.CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate     (cfg_rate),
      .ph       (ph),
      .boundary (boundary)
   );

   assign mid_byte = cfg_serial && act && (bits_left != '0);
   assign rd_en    = boundary && !mid_byte && cfg_oe && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act       <= 1'b0;
         sop_q     <= 1'b0;
         err_q     <= 1'b0;
         sh        <= '0;
         bits_left <= '0;
      end else if (boundary) begin
         if (mid_byte) begin
            sh        <= sh << 1;
            bits_left <= bits_left - 1'b1;
            sop_q     <= 1'b0;
         end else if (rd_en) begin
            sh        <= rd_ent[DATA_W-1:0];
            err_q     <= rd_ent[DATA_W];
            sop_q     <= rd_ent[DATA_W+1];
            act       <= 1'b1;
            bits_left <= cfg_serial ? BIT_W'(DATA_W - 1) : '0;
         end else begin
            act <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf <= 1'b0;
      else        ovf <= in_valid && full;
   end

   // pin stage
   logic [DATA_W-1:0] data_sel;

   if (DATA_W > 1) begin : g_serial_pad
      assign data_sel = cfg_serial ? {{(DATA_W-1){1'b0}}, sh[DATA_W-1]} : sh;
   end

   always_comb begin
      if (!cfg_oe) begin
         ts_clk   = 1'b0;
         ts_data  = '0;
         ts_sync  = 1'b0;
         ts_valid = 1'b0;
         ts_err   = 1'b0;
      end else begin
         ts_clk   = (cfg_clk_cont || act) ? (ph ^ cfg_clk_fall) : cfg_clk_fall;
         ts_data  = act ? data_sel : '0;
         ts_sync  = (act && sop_q) ^ cfg_sync_low;
         ts_valid = act ^ cfg_valid_low;
         ts_err   = (act && err_q) ^ cfg_err_low;
      end
   end
endmodule

// File: rtl/mso_stream_out_chk.sv
module mso_stream_out_chk #(
   parameter int DATA_W = 8,
   parameter int BIT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              ovf,
   input logic              cfg_serial,
   input logic              boundary,
   input logic              act,
   input logic              sop_q,
   input logic [BIT_W-1:0]  bits_left,
   input logic [DATA_W-1:0] sh,
   input logic              rd_en,
   input logic              empty
);
   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> $past(in_valid));

   // R3
   serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_serial && boundary && act && bits_left != '0) |=> act);

   // R4
   sync_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_serial && boundary && act && bits_left != '0) |=> !sop_q);

   // R9
   data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(sh));

   // R12
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (!empty && boundary));
endmodule

bind mso_stream_out mso_stream_out_chk #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .ovf        (ovf),
   .cfg_serial (cfg_serial),
   .boundary   (boundary),
   .act        (act),
   .sop_q      (sop_q),
   .bits_left  (bits_left),
   .sh         (sh),
   .rd_en      (rd_en),
   .empty      (empty)
);

// File: tb/tb_mso_stream_out.sv
module tb_mso_stream_out;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_sop = 1'b0, in_err = 1'b0;
   logic [7:0] in_data = '0;
   logic       cfg_oe = 1'b1, cfg_serial = 1'b0, cfg_clk_cont = 1'b1, cfg_clk_fall = 1'b0;
   logic       cfg_sync_low = 1'b0, cfg_valid_low = 1'b0, cfg_err_low = 1'b0;
   logic [2:0] cfg_rate = 3'd0;
   logic       ts_clk, ts_sync, ts_valid, ts_err, ovf;
   logic [7:0] ts_data;

   int checks = 0, errors = 0, ovf_seen = 0;

   always #5 clk = ~clk;

   mso_stream_out #(.DATA_W(8), .DEPTH(DEPTH), .CNT_W(5)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sop(in_sop), .in_err(in_err), .cfg_oe(cfg_oe), .cfg_serial(cfg_serial),
      .cfg_clk_cont(cfg_clk_cont), .cfg_clk_fall(cfg_clk_fall),
      .cfg_sync_low(cfg_sync_low), .cfg_valid_low(cfg_valid_low),
      .cfg_err_low(cfg_err_low), .cfg_rate(cfg_rate), .ts_clk(ts_clk),
      .ts_data(ts_data), .ts_sync(ts_sync), .ts_valid(ts_valid),
      .ts_err(ts_err), .ovf(ovf));

   function automatic int hp(input logic [2:0] c);
      int t [8] = '{1, 3, 5, 7, 9, 13, 17, 20};
      return t[c];
   endfunction

   task automatic chk(input string req, input int act_v, input int exp_v);
      checks++;
      if (act_v != exp_v) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act_v, exp_v);
      end
   endtask

   // behavioural reference
   int       m_cnt = 0, m_left = 0;
   bit       m_ph = 0, m_act = 0, m_sop = 0, m_err = 0, m_ovf = 0, m_cur_err = 0;
   bit [7:0] m_sh = 0;
   bit [9:0] m_q [$];

   always @(posedge clk) begin
      int       h;
      bit       bnd, full_pre, have;
      bit [9:0] head;
      if (!rst_n) begin
         m_cnt = 0; m_ph = 0; m_act = 0; m_sop = 0; m_err = 0; m_ovf = 0;
         m_cur_err = 0; m_sh = 0; m_left = 0; m_q.delete();
      end else begin
         h        = hp(cfg_rate);
         bnd      = (m_cnt >= h - 1) && m_ph;
         full_pre = (m_q.size() >= DEPTH);
         have     = (m_q.size() > 0);
         if (m_cnt >= h - 1) begin m_cnt = 0; m_ph = !m_ph; end
         else m_cnt++;
         if (bnd) begin
            if (cfg_serial && m_act && m_left != 0) begin
               m_sh = m_sh << 1; m_left--; m_sop = 0;
            end else if (cfg_oe && have) begin
               head = m_q.pop_front();
               m_sh = head[7:0]; m_err = head[8]; m_sop = head[9];
               m_act = 1; m_left = cfg_serial ? 7 : 0;
            end else m_act = 0;
         end
         m_ovf = in_valid && full_pre;
         if (in_valid && !full_pre)
            m_q.push_back({in_sop, (in_sop ? in_err : m_cur_err), in_data});
         if (in_valid && in_sop) m_cur_err = in_err;
      end
   end

   // per-cycle comparison, away from the clock edge
   always @(posedge clk) begin
      bit       e_clk, e_sync, e_valid, e_err;
      bit [7:0] e_data;
      #2;
      if (rst_n) begin
         if (!cfg_oe) begin
            e_clk = 0; e_data = 0; e_sync = 0; e_valid = 0; e_err = 0;
         end else begin
            e_clk   = (cfg_clk_cont || m_act) ? (m_ph ^ cfg_clk_fall) : cfg_clk_fall;
            e_data  = !m_act ? 8'h00 : (cfg_serial ? {7'b0, m_sh[7]} : m_sh);
            e_sync  = (m_act && m_sop) ^ cfg_sync_low;
            e_valid = m_act ^ cfg_valid_low;
            e_err   = (m_act && m_err) ^ cfg_err_low;
         end
         chk("R7 R8 clock pin", ts_clk, e_clk);
         chk("R2 R3 R12 data", ts_data, e_data);
         chk("R4 sync", ts_sync, e_sync);
         chk("R6 valid", ts_valid, e_valid);
         chk("R5 err", ts_err, e_err);
         chk("R11 ovf", ovf, m_ovf);
         if (ovf) ovf_seen++;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input bit [7:0] d, input bit s, input bit e);
      @(negedge clk);
      in_valid = 1; in_data = d; in_sop = s; in_err = e;
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_err = 0;
   endtask

   // err flag given on every byte of the packet only as a stimulus; R5 says only the start byte counts
   task automatic send_pkt(input int len, input bit [7:0] base, input bit e, input int gap);
      for (int i = 0; i < len; i++) begin
         send(base + 8'(i), i == 0, (i == 0) ? e : ~e);
         idle(gap);
      end
   endtask

   task automatic measure_period(input logic [2:0] code);
      int  n;
      bit  prev;
      cfg_rate = code;
      idle(50);
      @(posedge ts_clk);
      @(negedge clk);
      n = 0; prev = ts_clk;
      forever begin
         @(negedge clk); n++;
         if (ts_clk && !prev) break;
         prev = ts_clk;
      end
      chk("R9 clock period", n, 2 * hp(code));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      idle(3);
      chk("R1 clock", ts_clk, 0);
      chk("R1 data", ts_data, 0);
      chk("R1 sync", ts_sync, 0);
      chk("R1 valid", ts_valid, 0);
      chk("R1 err", ts_err, 0);
      chk("R1 ovf", ovf, 0);
      rst_n = 1;
      idle(4);

      // parallel, continuous, rate 0
      send_pkt(5, 8'h10, 0, 3);
      send_pkt(5, 8'hA0, 1, 3);
      idle(20);

      // R9 periods in continuous mode
      measure_period(3'd0);
      measure_period(3'd1);
      measure_period(3'd2);

      // serial, gated, falling capture, all strobes active low
      cfg_rate = 3'd0; cfg_serial = 1; cfg_clk_cont = 0; cfg_clk_fall = 1;
      cfg_sync_low = 1; cfg_valid_low = 1; cfg_err_low = 1;
      idle(10);
      send_pkt(3, 8'hC5, 1, 20);
      send_pkt(2, 8'h3A, 0, 20);
      idle(40);

      // parallel, gated, rate 3, mixed polarity
      cfg_serial = 0; cfg_rate = 3'd3; cfg_clk_fall = 0; cfg_valid_low = 0;
      idle(10);
      send_pkt(4, 8'h55, 1, 16);
      idle(60);

      // R10 / R11: disabled port, burst overflow
      cfg_oe = 0; cfg_rate = 3'd0;
      idle(20);
      ovf_seen = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_valid = 1; in_data = 8'hE0 + 8'(i); in_sop = (i == 0); in_err = 0;
      end
      @(negedge clk); in_valid = 0; in_sop = 0;
      idle(30);
      chk("R11 dropped byte pulses", ovf_seen, 2);
      chk("R10 clock held low", ts_clk, 0);
      chk("R10 valid held low", ts_valid, 0);
      chk("R10 sync held low", ts_sync, 0);
      chk("R10 err held low", ts_err, 0);
      cfg_oe = 1;
      idle(30);

      // serial continuous rate 1, rate change mid-run
      cfg_serial = 1; cfg_clk_cont = 1; cfg_rate = 3'd1; cfg_err_low = 0;
      send_pkt(3, 8'h81, 1, 50);
      cfg_rate = 3'd0;
      send_pkt(2, 8'h7E, 0, 20);
      idle(60);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule